// File: doc/BRIEF.md
# Signed Maximum Execute Unit

This block is a single-cycle integer execution unit for one 32-bit instruction: a signed maximum of two 64-bit register values. It checks the instruction word against a fixed encoding and pulls out the destination and source register indices. When the word matches, it selects the larger operand, comparing them as two's complement numbers. If the record bit is set, it also forms a 4-bit condition field that describes the sign of the selected value.

An issue stage presents the instruction word with a valid strobe, the two operand values already read from the register file, and the current summary-overflow bit. Exactly one clock later the unit presents the decoded indices, a legal/illegal outcome, the result with its write enable, and the condition field with its own write enable. The bit numbering below counts word bit 31 as the most significant bit and bit 0 as the least significant bit.

Top module: `smax_exec_unit`

## Requirements
- R1: Each input cycle appears at the outputs one clock later: `out_valid` equals `in_valid` from the previous cycle. A synchronous active-high reset clears every output to zero.
- R2: A word is a match only when bits 31:26 equal 22 (decimal) and bits 10:1 equal 10'b0111001110.
- R3: For every valid word, `rt_idx` takes bits 25:21, `ra_idx` takes bits 20:16 and `rb_idx` takes bits 15:11.
- R4: On a match, `result` is operand A when A >= B as signed 64-bit values, and operand B otherwise. Equal operands give A. On the same cycle `res_we` is 1.
- R5: A valid word that does not match sets `illegal` to 1 and sets `res_we` and `cond_we` to 0. In that case `result` and `cond` keep their previous values.
- R6: Bit 0 of the word is the record bit. When a matching word has this bit at 1, `cond_we` is 1 and `cond` is updated. When the bit is 0, `cond_we` is 0 and `cond` keeps its previous value.
- R7: `cond[3:1]` is 3'b100 for a negative result, 3'b010 for a positive non-zero result and 3'b001 for a zero result.
- R8: `cond[0]` is a copy of `so_in` sampled with the instruction.
- R9: In a cycle after an idle input cycle, `out_valid`, `res_we`, `illegal` and `cond_we` are all 0, and `result`, `cond` and the indices keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present |
| insn | input | 32 | Instruction word |
| opnd_a | input | 64 | First operand (RA value) |
| opnd_b | input | 64 | Second operand (RB value) |
| so_in | input | 1 | Summary-overflow bit |
| out_valid | output | 1 | Registered outcome is present |
| rt_idx | output | 5 | Destination register index |
| ra_idx | output | 5 | First source register index |
| rb_idx | output | 5 | Second source register index |
| illegal | output | 1 | Valid word did not match |
| result | output | 64 | Signed maximum |
| res_we | output | 1 | Result write enable |
| cond | output | 4 | Condition field |
| cond_we | output | 1 | Condition field write enable |

## Verification
The tests cover these operand pairs:
- Two negative 64-bit values, applied in both orders. This shows that the selection follows the signed value and not the operand position.
- 1 against the most negative number. An unsigned comparison would pick the wrong operand here.
- A negative value against zero, which gives the zero encoding.
- Equal operands, which show the tie goes to A.
- 1 against 0, which gives the positive encoding.

Separate tests use words with a wrong primary opcode or a wrong extended opcode, and words with the record bit clear. These show that the write enables separate from each other and that the held result and condition values stay put. A test with the summary-overflow bit set separates the low condition bit from the sign encoding.

// File: rtl/smax_pkg.sv
package smax_pkg;
    localparam int INSN_W   = 32;
    localparam int IDX_W    = 5;
    localparam int POP_W    = 6;
    localparam int XOP_W    = 10;
    localparam int COND_W   = 4;

    localparam int POP_LSB  = INSN_W - POP_W;
    localparam int RT_LSB   = POP_LSB - IDX_W;
    localparam int RA_LSB   = RT_LSB - IDX_W;
    localparam int RB_LSB   = RA_LSB - IDX_W;
    localparam int XOP_LSB  = 1;
    localparam int REC_BIT  = 0;

    localparam int COND_NEG  = 3;
    localparam int COND_POS  = 2;
    localparam int COND_ZERO = 1;
    localparam int COND_SO   = 0;

    typedef struct packed {
        logic [IDX_W-1:0] rt;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] rb;
        logic             match;
        logic             rec;
    } dec_t;
endpackage

// File: rtl/smax_decode.sv
module smax_decode
    import smax_pkg::*;
#(
    parameter logic [POP_W-1:0] PRIMARY_OP = 6'd22,
    parameter logic [XOP_W-1:0] EXT_OP     = 10'b0111001110
) (
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [POP_W-1:0] pop_f;
    logic [XOP_W-1:0] xop_f;

    always_comb begin
        pop_f     = insn[POP_LSB +: POP_W];
        xop_f     = insn[XOP_LSB +: XOP_W];
        dec.rt    = insn[RT_LSB +: IDX_W];
        dec.ra    = insn[RA_LSB +: IDX_W];
        dec.rb    = insn[RB_LSB +: IDX_W];
        dec.rec   = insn[REC_BIT];
        dec.match = (pop_f == PRIMARY_OP) && (xop_f == EXT_OP);
    end
endmodule

// File: rtl/smax_select.sv
module smax_select #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] max_v
);
    logic a_ge_b;

    always_comb begin
        // Signs differ: the non-negative side wins; otherwise a plain compare works.
        if (a[XLEN-1] != b[XLEN-1]) a_ge_b = ~a[XLEN-1];
        else                        a_ge_b = (a[XLEN-2:0] >= b[XLEN-2:0]);
        max_v = a_ge_b ? a : b;
    end
endmodule

// File: rtl/smax_cond.sv
module smax_cond
    import smax_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   value,
    input  logic              so,
    output logic [COND_W-1:0] cf
);
    logic is_zero;

    always_comb begin
        is_zero       = (value == '0);
        cf            = '0;
        cf[COND_NEG]  = value[XLEN-1];
        cf[COND_POS]  = ~value[XLEN-1] & ~is_zero;
        cf[COND_ZERO] = is_zero;
        cf[COND_SO]   = so;
    end
endmodule

// File: rtl/smax_exec_unit.sv
module smax_exec_unit
    import smax_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSN_W-1:0]   insn,
    input  logic [XLEN-1:0]     opnd_a,
    input  logic [XLEN-1:0]     opnd_b,
    input  logic                so_in,
    output logic                out_valid,
    output logic [IDX_W-1:0]    rt_idx,
    output logic [IDX_W-1:0]    ra_idx,
    output logic [IDX_W-1:0]    rb_idx,
    output logic                illegal,
    output logic [XLEN-1:0]     result,
    output logic                res_we,
    output logic [COND_W-1:0]   cond,
    output logic                cond_we
);
    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  rt;
        logic [IDX_W-1:0]  ra;
        logic [IDX_W-1:0]  rb;
        logic              ill;
        logic [XLEN-1:0]   res;
        logic              res_we;
        logic [COND_W-1:0] cf;
        logic              cf_we;
    } out_t;

    dec_t              dec;
    logic [XLEN-1:0]   max_v;
    logic [COND_W-1:0] cf_v;
    out_t              st_d, st_q;

    smax_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    smax_select #(.XLEN(XLEN)) u_sel (
        .a     (opnd_a),
        .b     (opnd_b),
        .max_v (max_v)
    );

    smax_cond #(.XLEN(XLEN)) u_cond (
        .value (max_v),
        .so    (so_in),
        .cf    (cf_v)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = in_valid;
        st_d.ill    = 1'b0;
        st_d.res_we = 1'b0;
        st_d.cf_we  = 1'b0;
        if (in_valid) begin
            st_d.rt  = dec.rt;
            st_d.ra  = dec.ra;
            st_d.rb  = dec.rb;
            st_d.ill = ~dec.match;
            if (dec.match) begin
                st_d.res    = max_v;
                st_d.res_we = 1'b1;
                if (dec.rec) begin
                    st_d.cf    = cf_v;
                    st_d.cf_we = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign rt_idx    = st_q.rt;
    assign ra_idx    = st_q.ra;
    assign rb_idx    = st_q.rb;
    assign illegal   = st_q.ill;
    assign result    = st_q.res;
    assign res_we    = st_q.res_we;
    assign cond      = st_q.cf;
    assign cond_we   = st_q.cf_we;
endmodule

// File: rtl/smax_exec_checker.sv
module smax_exec_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic            so_in,
    input logic            out_valid,
    input logic            illegal,
    input logic [XLEN-1:0] result,
    input logic            res_we,
    input logic [3:0]      cond,
    input logic            cond_we
);
    // R1: valid tracks the input strobe one cycle later
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R9: idle input gives idle outputs
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !res_we && !illegal && !cond_we));
    // R5: a valid outcome is either a write or an illegal flag, never both
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones({res_we, illegal}) == 1));
    // R6: condition write only accompanies a result write
    a_r6_cond_needs_res: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> res_we);
    // R6: condition held when not written
    a_r6_cond_hold: assert property (@(posedge clk) disable iff (rst)
        !cond_we |-> $stable(cond));
    // R5: result held when not written
    a_r5_res_hold: assert property (@(posedge clk) disable iff (rst)
        !res_we |-> $stable(result));
    // R4: written result is one of the operands and not below either
    a_r4_is_max: assert property (@(posedge clk) disable iff (rst)
        res_we |-> ((result == $past(opnd_a) || result == $past(opnd_b))
                    && $signed(result) >= $signed($past(opnd_a))
                    && $signed(result) >= $signed($past(opnd_b))));
    // R7: exactly one sign code when written
    a_r7_one_code: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> ($onehot(cond[3:1]) && (cond[3] == result[XLEN-1])));
    // R8: low condition bit copies the overflow input
    a_r8_so_copy: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (cond[0] == $past(so_in)));
endmodule

bind smax_exec_unit smax_exec_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .so_in     (so_in),
    .out_valid (out_valid),
    .illegal   (illegal),
    .result    (result),
    .res_we    (res_we),
    .cond      (cond),
    .cond_we   (cond_we)
);

// File: tb/smax_exec_unit_tb.sv
module smax_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] insn;
    logic [63:0] opnd_a, opnd_b;
    logic        so_in;
    logic        out_valid, illegal, res_we, cond_we;
    logic [4:0]  rt_idx, ra_idx, rb_idx;
    logic [63:0] result;
    logic [3:0]  cond;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smax_exec_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .so_in(so_in),
        .out_valid(out_valid), .rt_idx(rt_idx), .ra_idx(ra_idx), .rb_idx(rb_idx),
        .illegal(illegal), .result(result), .res_we(res_we),
        .cond(cond), .cond_we(cond_we)
    );

    function automatic logic [31:0] enc(input logic [5:0] pop, input logic [4:0] rt,
                                        input logic [4:0] ra, input logic [4:0] rb,
                                        input logic [9:0] xop, input logic rec);
        return {pop, rt, ra, rb, xop, rec};
    endfunction

    localparam logic [9:0] XOP = 10'b0111001110;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with outputs registered.
    task automatic issue(input logic [31:0] w, input logic [63:0] a,
                         input logic [63:0] b, input logic so);
        in_valid = 1'b1; insn = w; opnd_a = a; opnd_b = b; so_in = so;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset valid", 64'(out_valid), 0);
        chk("R1 reset result", result, 0);
        chk("R1 reset cond", 64'(cond), 0);
        chk("R1 reset enables", 64'({res_we, cond_we, illegal}), 0);
    endtask

    task automatic t_neg_pair;
        issue(enc(22, 3, 1, 2, XOP, 1), 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 0);
        chk("R1 valid", 64'(out_valid), 1);
        chk("R4 neg pair ab", result, 64'he1e5b9cc9864c4a8);
        chk("R7 neg code", 64'(cond), 4'h8);
        chk("R6 cond_we", 64'(cond_we), 1);
        chk("R3 indices", 64'({rt_idx, ra_idx, rb_idx}), 64'({5'd3, 5'd1, 5'd2}));
        issue(enc(22, 3, 1, 2, XOP, 1), 64'he1e5b9cc9864c4a8, 64'hc523e996a8ff6215, 0);
        chk("R4 neg pair ba", result, 64'he1e5b9cc9864c4a8);
    endtask

    task automatic t_min_neg;
        issue(enc(22, 7, 9, 30, XOP, 1), 64'd1, 64'h8000_0000_0000_0000, 0);
        chk("R4 most negative", result, 64'd1);
        chk("R7 pos code", 64'(cond), 4'h4);
        chk("R3 indices 2", 64'({rt_idx, ra_idx, rb_idx}), 64'({5'd7, 5'd9, 5'd30}));
    endtask

    task automatic t_zero_and_tie;
        issue(enc(22, 3, 1, 2, XOP, 1), 64'hc523e996a8ff6215, 64'd0, 0);
        chk("R4 zero wins", result, 64'd0);
        chk("R7 zero code", 64'(cond), 4'h2);
        issue(enc(22, 3, 1, 2, XOP, 1), 64'hffff_ffff_ffff_fff0, 64'hffff_ffff_ffff_fff0, 0);
        chk("R4 tie", result, 64'hffff_ffff_ffff_fff0);
        chk("R7 tie neg", 64'(cond), 4'h8);
    endtask

    task automatic t_so;
        issue(enc(22, 3, 1, 2, XOP, 1), 64'd1, 64'd0, 1);
        chk("R8 so copy", 64'(cond), 4'h5);
    endtask

    task automatic t_no_record;
        issue(enc(22, 3, 1, 2, XOP, 0), 64'd0, 64'hffff_ffff_ffff_ffff, 0);
        chk("R6 no record result", result, 64'd0);
        chk("R6 no record res_we", 64'(res_we), 1);
        chk("R6 no record cond_we", 64'(cond_we), 0);
        chk("R6 cond held", 64'(cond), 4'h5);
    endtask

    task automatic t_illegal;
        issue(enc(21, 4, 5, 6, XOP, 1), 64'd77, 64'd88, 0);
        chk("R2 bad primary illegal", 64'(illegal), 1);
        chk("R5 bad primary enables", 64'({res_we, cond_we}), 0);
        chk("R5 result held", result, 64'd0);
        chk("R5 cond held", 64'(cond), 4'h5);
        chk("R3 indices on illegal", 64'({rt_idx, ra_idx, rb_idx}), 64'({5'd4, 5'd5, 5'd6}));
        issue(enc(22, 4, 5, 6, XOP ^ 10'h200, 1), 64'd77, 64'd88, 0);
        chk("R2 bad ext illegal", 64'(illegal), 1);
        chk("R5 bad ext result", result, 64'd0);
        issue(enc(22, 4, 5, 6, XOP, 1), 64'd77, 64'd88, 0);
        chk("R2 good word legal", 64'({illegal, res_we}), 64'b01);
        chk("R4 positive pick", result, 64'd88);
    endtask

    task automatic t_idle;
        @(negedge clk);
        chk("R9 idle flags", 64'({out_valid, res_we, illegal, cond_we}), 0);
        chk("R9 idle result held", result, 64'd88);
        chk("R9 idle cond held", 64'(cond), 4'h4);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; insn = '0; opnd_a = '0; opnd_b = '0; so_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_neg_pair();
        t_min_neg();
        t_zero_and_tie();
        t_so();
        t_no_record();
        t_illegal();
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule